// File: doc/BRIEF.md
# VME Slave Front End with Configuration Space and Window Decoder

This block is the slave side of a VME64x-style bus port, reduced to what a board needs to be found and enabled by a bus master. It has a small configuration space, reached with the configuration address modifier (0x2F) and the board's slot (geographic) address. That space holds a base-address byte that echoes the slot, a module enable bit with set and clear locations, and a single address window made of a compare byte and an address-modifier byte.

Once the module is enabled, the block answers A32 data reads. The upper address byte must match the window compare byte, and the cycle's address modifier must match the stored one. It returns single bytes or aligned 16-bit words from a fixed back-end pattern source. The bus strobes pass through two-flop synchronizers. A small control state machine drives the acknowledge, the transceiver direction and the data output enable, and holds the acknowledge until the master lets go of the strobes.

Top module: `vme_slave_front`

## Requirements
- R1: After reset, dtackOe is 0, dtackN is 1, dataDir is 0 and dataOeN is 1. The module is disabled and both window bytes are zero.
- R2: A single-byte configuration read at offset 0x7FFFF returns the 5-bit slot address followed by three zero bits, on dataOut[7:0].
- R3: A cycle is a configuration cycle when amIn is 0x2F and addrIn[23:19] equals geoAddr. Only single-byte cycles with lwordN and iackN high are accepted, and they are answered whether or not the module is enabled. A cycle with any other slot gets no acknowledge.
- R4: A configuration write with dataIn bit 4 set has the following effects. At offset 0x7FFFB it enables the module. At offset 0x7FFF7 it disables it. A read of either offset returns 0x10 when enabled and 0x00 when disabled.
- R5: The window compare byte sits at configuration offset 0x7FF63. The window modifier byte sits at 0x7FF6F and holds the address modifier shifted left by two. Both read back as written.
- R6: A data cycle is acknowledged only if all of these hold: the module is enabled, addrIn[31:24] equals the compare byte, {amIn,2'b00} equals the modifier byte, writeN, lwordN and iackN are high, and at least one data strobe is low. Any other cycle gets no acknowledge.
- R7: A single-byte data read works as follows. dsN=2'b10 (strobe 0 low) selects the odd byte and dsN=2'b01 selects the even byte. The byte appears on dataOut[7:0] with dataOut[15:8] zero. The byte at window offset n is n XOR 0x3C.
- R8: A 16-bit data read (dsN=2'b00) returns the even byte on dataOut[15:8] and the next odd byte on dataOut[7:0].
- R9: While a read is acknowledged, dtackOe=1, dtackN=0, dataDir=1 and dataOeN=0. While a write is acknowledged, dataDir=0 and dataOeN=1.
- R10: The acknowledge stays asserted until asN and both dsN bits have been seen high. After that, dtackOe returns to 0.
- R11: Strobes pass through two synchronizer flops. When asN and dsN fall just after a rising edge, dtackN is still high after the second following rising edge and low after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| geoAddr | input | 5 | Slot (geographic) address |
| addrIn | input | 31 | Bus address bits 31:1 |
| amIn | input | 6 | Address modifier |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 2 | Data strobes, active low |
| writeN | input | 1 | Low for a write cycle |
| lwordN | input | 1 | Low for a 32-bit cycle |
| iackN | input | 1 | Low for interrupt acknowledge |
| dataIn | input | 8 | Write data byte |
| dataOut | output | 16 | Read data |
| dtackN | output | 1 | Data acknowledge, active low |
| dtackOe | output | 1 | Acknowledge driver enable |
| dataDir | output | 1 | Transceiver direction, 1 = slave drives |
| dataOeN | output | 1 | Transceiver output enable, active low |

## Verification
The hardest case to reach is a data cycle that matches the window in every field but one. That one field can be the enable state, the compare byte, the stored modifier, the cycle width or the direction. The bench first programs the window through configuration writes while the module is still disabled. It then toggles the enable through both the set and the clear locations. Finally it runs a seeded random mix of reads in which each of the upper address byte, the modifier, the strobe pattern and the width flag is chosen to match or miss independently. A reference model predicts both whether the cycle is acknowledged and the data returned.

// File: rtl/vslv_pkg.sv
package vslv_pkg;
  localparam logic [5:0]  CFG_AM   = 6'h2F;
  localparam logic [18:0] OFF_BASE = 19'h7FFFF;
  localparam logic [18:0] OFF_SET  = 19'h7FFFB;
  localparam logic [18:0] OFF_CLR  = 19'h7FFF7;
  localparam logic [18:0] OFF_WCMP = 19'h7FF63;
  localparam logic [18:0] OFF_WAM  = 19'h7FF6F;
  localparam int          EN_BIT   = 4;
  localparam logic [7:0]  PAT_KEY  = 8'h3C;

  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_MISS} busState_t;

  typedef struct packed {
    logic       capture;
    logic       doWrite;
    logic       rd;
    logic [1:0] ds;
  } busStrobe_t;

  function automatic logic [7:0] patByte(input logic [7:0] idx);
    return idx ^ PAT_KEY;
  endfunction
endpackage

// File: rtl/vslv_datapath.sv
module vslv_datapath
  import vslv_pkg::*;
#(
  parameter int GEO_W    = 5,
  parameter int ARRAY_AW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       st,
  input  logic [GEO_W-1:0] geoAddr,
  input  logic [31:1]      addrIn,
  input  logic [5:0]       amIn,
  input  logic             lwordN,
  input  logic             iackN,
  input  logic [7:0]       dataIn,
  output logic             hit,
  output logic [15:0]      dataOut
);
  localparam int GEO_LO = 19;
  localparam int GEO_HI = GEO_LO + GEO_W - 1;

  logic       enable;
  logic [7:0] winCmp;
  logic [7:0] winAm;
  logic       single, anyDs, a0;
  logic       cfgHit, dataHit;
  logic [18:0] cfgOff;
  logic [ARRAY_AW-1:0] evenIdx, byteIdx;
  logic [7:0] cfgVal;
  logic [15:0] rdWord;

  always_comb begin
    single  = (st.ds == 2'b01) || (st.ds == 2'b10);
    anyDs   = (st.ds != 2'b11);
    a0      = (st.ds == 2'b10);
    cfgOff  = {addrIn[18:1], a0};
    evenIdx = {addrIn[ARRAY_AW-1:1], 1'b0};
    byteIdx = {addrIn[ARRAY_AW-1:1], a0};
    cfgHit  = (amIn == CFG_AM) && (addrIn[GEO_HI:GEO_LO] == geoAddr)
              && single && lwordN && iackN;
    dataHit = enable && (addrIn[31:24] == winCmp) && ({amIn, 2'b00} == winAm)
              && st.rd && anyDs && lwordN && iackN;
    hit     = cfgHit || dataHit;
  end

  always_comb begin
    unique case (cfgOff)
      OFF_BASE:          cfgVal = {geoAddr, 3'b000};
      OFF_SET, OFF_CLR:  cfgVal = 8'(enable) << EN_BIT;
      OFF_WCMP:          cfgVal = winCmp;
      OFF_WAM:           cfgVal = winAm;
      default:           cfgVal = 8'h00;
    endcase
  end

  always_comb begin
    if (cfgHit)
      rdWord = {8'h00, cfgVal};
    else if (st.ds == 2'b00)
      rdWord = {patByte(8'(evenIdx)), patByte(8'(evenIdx | 1))};
    else
      rdWord = {8'h00, patByte(8'(byteIdx))};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      winCmp  <= '0;
      winAm   <= '0;
      dataOut <= '0;
    end else begin
      if (st.capture) dataOut <= rdWord;
      if (st.doWrite && cfgHit) begin
        unique case (cfgOff)
          OFF_SET:  if (dataIn[EN_BIT]) enable <= 1'b1;
          OFF_CLR:  if (dataIn[EN_BIT]) enable <= 1'b0;
          OFF_WCMP: winCmp <= dataIn;
          OFF_WAM:  winAm  <= dataIn;
          default:  ;
        endcase
      end
    end
  end

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (st.doWrite && cfgHit && cfgOff == OFF_SET && dataIn[EN_BIT]) |=> enable); // R4
  AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !st.doWrite |=> ($stable(winCmp) && $stable(winAm))); // R5
endmodule

// File: rtl/vslv_ctrl.sv
module vslv_ctrl
  import vslv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       asN,
  input  logic [1:0] dsN,
  input  logic       writeN,
  input  logic       hit,
  output busStrobe_t st,
  output logic       dtackN,
  output logic       dtackOe,
  output logic       dataDir,
  output logic       dataOeN
);
  logic [1:0] asSh, wrSh;
  logic [1:0] dsMeta, dsS;
  logic       asS, wrS, strobe, released, isRd;
  busState_t  state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asSh   <= 2'b11;
      wrSh   <= 2'b11;
      dsMeta <= 2'b11;
      dsS    <= 2'b11;
    end else begin
      asSh   <= {asSh[0], asN};
      wrSh   <= {wrSh[0], writeN};
      dsMeta <= dsN;
      dsS    <= dsMeta;
    end
  end

  always_comb begin
    asS        = asSh[1];
    wrS        = wrSh[1];
    strobe     = !asS && (dsS != 2'b11);
    released   = asS && (dsS == 2'b11);
    st.ds      = dsS;
    st.rd      = wrS;
    st.capture = (state == ST_IDLE) && strobe && hit;
    st.doWrite = st.capture && !wrS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isRd  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (strobe) begin
          state <= hit ? ST_ACK : ST_MISS;
          isRd  <= wrS;
        end
        ST_ACK, ST_MISS: if (released) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dtackOe = (state == ST_ACK);
  assign dtackN  = !(state == ST_ACK);
  assign dataDir = (state == ST_ACK) && isRd;
  assign dataOeN = !((state == ST_ACK) && isRd);

  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (dtackOe && !released) |=> dtackOe); // R10
  AST_DROP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtackOe) |-> $past(released)); // R10
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dtackOe) |-> $past(strobe)); // R11
endmodule

// File: rtl/vme_slave_front.sv
module vme_slave_front
  import vslv_pkg::*;
#(
  parameter int GEO_W    = 5,
  parameter int ARRAY_AW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [GEO_W-1:0] geoAddr,
  input  logic [31:1]      addrIn,
  input  logic [5:0]       amIn,
  input  logic             asN,
  input  logic [1:0]       dsN,
  input  logic             writeN,
  input  logic             lwordN,
  input  logic             iackN,
  input  logic [7:0]       dataIn,
  output logic [15:0]      dataOut,
  output logic             dtackN,
  output logic             dtackOe,
  output logic             dataDir,
  output logic             dataOeN
);
  busStrobe_t st;
  logic       hit;

  vslv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .writeN(writeN), .hit(hit),
    .st(st), .dtackN(dtackN), .dtackOe(dtackOe), .dataDir(dataDir), .dataOeN(dataOeN)
  );

  vslv_datapath #(.GEO_W(GEO_W), .ARRAY_AW(ARRAY_AW)) u_datapath (
    .clk(clk), .rstN(rstN), .st(st), .geoAddr(geoAddr), .addrIn(addrIn), .amIn(amIn),
    .lwordN(lwordN), .iackN(iackN), .dataIn(dataIn), .hit(hit), .dataOut(dataOut)
  );
endmodule

// File: tb/vme_slave_front_bench.sv
module vme_slave_front_bench;
  localparam logic [4:0] GEO = 5'h0B;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:1] addrIn = '0;
  logic [5:0]  amIn = '0;
  logic        asN = 1'b1, writeN = 1'b1, lwordN = 1'b1, iackN = 1'b1;
  logic [1:0]  dsN = 2'b11;
  logic [7:0]  dataIn = '0;
  logic [15:0] dataOut;
  logic        dtackN, dtackOe, dataDir, dataOeN;

  int nChecks = 0;
  int nErr = 0;

  bit         mEn = 0;
  logic [7:0] mCmp = 8'h00, mAm = 8'h00;

  always #4 clk = ~clk;

  vme_slave_front u_vme_slave_front (
    .clk(clk), .rstN(rstN), .geoAddr(GEO), .addrIn(addrIn), .amIn(amIn), .asN(asN),
    .dsN(dsN), .writeN(writeN), .lwordN(lwordN), .iackN(iackN), .dataIn(dataIn),
    .dataOut(dataOut), .dtackN(dtackN), .dtackOe(dtackOe), .dataDir(dataDir), .dataOeN(dataOeN)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] n);
    return n ^ 8'h3C;
  endfunction

  function automatic logic [7:0] cfgModel(input logic [18:0] off);
    case (off)
      19'h7FFFF: return {GEO, 3'b000};
      19'h7FFFB, 19'h7FFF7: return mEn ? 8'h10 : 8'h00;
      19'h7FF63: return mCmp;
      19'h7FF6F: return mAm;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void predict(input logic [31:0] a, input logic [5:0] am, input logic [1:0] ds,
                                  input bit wr, input bit lw, output bit ack, output logic [15:0] d);
    bit single = (ds == 2'b01) || (ds == 2'b10);
    logic a0 = (ds == 2'b10);
    logic [7:0] ev = {a[7:1], 1'b0};
    ack = 0;
    d = 16'h0;
    if (am == 6'h2F && a[23:19] == GEO && single && lw) begin
      ack = 1;
      d = {8'h00, cfgModel({a[18:1], a0})};
    end else if (mEn && a[31:24] == mCmp && {am, 2'b00} == mAm && !wr && lw && ds != 2'b11) begin
      ack = 1;
      if (ds == 2'b00) d = {pat(ev), pat(ev | 8'h01)};
      else d = {8'h00, pat({a[7:1], a0})};
    end
  endfunction

  task automatic runCycle(input logic [31:0] a, input logic [5:0] am, input logic [1:0] ds,
                          input bit wr, input logic [7:0] wd, input bit lw,
                          output bit acked, output logic [15:0] rdat, output logic dir, output logic oen);
    acked = 0; rdat = '0; dir = 0; oen = 1;
    @(negedge clk);
    for (int i = 0; i < 8 && dtackOe; i++) @(negedge clk);
    addrIn = a[31:1]; amIn = am; writeN = !wr; lwordN = !lw ? 1'b0 : 1'b1; iackN = 1'b1; dataIn = wd;
    @(negedge clk);
    asN = 1'b0; dsN = ds;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!dtackN && dtackOe) begin
        acked = 1; rdat = dataOut; dir = dataDir; oen = dataOeN;
        break;
      end
    end
    asN = 1'b1; dsN = 2'b11;
    for (int i = 0; i < 8 && dtackOe; i++) @(negedge clk);
    chk("R10 release", 16'(dtackOe), 16'h0);
  endtask

  task automatic cfgRd(input logic [18:0] off, output logic [7:0] v);
    bit ack; logic [15:0] d; logic dir, oen;
    runCycle({8'h00, GEO, off}, 6'h2F, off[0] ? 2'b10 : 2'b01, 0, 8'h00, 1, ack, d, dir, oen);
    chk("R3 cfg ack", 16'(ack), 16'h1);
    v = d[7:0];
  endtask

  task automatic cfgWr(input logic [18:0] off, input logic [7:0] v);
    bit ack; logic [15:0] d; logic dir, oen;
    runCycle({8'h00, GEO, off}, 6'h2F, 2'b10, 1, v, 1, ack, d, dir, oen);
    chk("R3 cfg write ack", 16'(ack), 16'h1);
    chk("R9 write dir", 16'(dir), 16'h0);
    chk("R9 write oen", 16'(oen), 16'h1);
  endtask

  task automatic dataCheck(input string req, input logic [31:0] a, input logic [5:0] am,
                           input logic [1:0] ds, input bit wr, input bit lw);
    bit ack, eAck; logic [15:0] d, eD; logic dir, oen;
    predict(a, am, ds, wr, lw, eAck, eD);
    runCycle(a, am, ds, wr, 8'h00, lw, ack, d, dir, oen);
    chk({req, " ack"}, 16'(ack), 16'(eAck));
    if (eAck && ack) begin
      chk({req, " data"}, d, eD);
      if (!wr) begin
        chk("R9 read dir", 16'(dir), 16'h1);
        chk("R9 read oen", 16'(oen), 16'h0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dtackOe", 16'(dtackOe), 16'h0);
    chk("R1 dtackN", 16'(dtackN), 16'h1);
    chk("R1 dataDir", 16'(dataDir), 16'h0);
    chk("R1 dataOeN", 16'(dataOeN), 16'h1);

    cfgRd(19'h7FFFF, v); chk("R2 base byte", 16'(v), 16'h0058);
    cfgRd(19'h7FF63, v); chk("R1 R5 cmp reset", 16'(v), 16'h0);
    cfgRd(19'h7FF6F, v); chk("R1 R5 am reset", 16'(v), 16'h0);
    cfgRd(19'h7FFFB, v); chk("R1 R4 enable reset", 16'(v), 16'h0);

    cfgWr(19'h7FF63, 8'h56); mCmp = 8'h56;
    cfgWr(19'h7FF6F, 8'h24); mAm = 8'h24;
    cfgRd(19'h7FF63, v); chk("R5 cmp readback", 16'(v), 16'h56);
    cfgRd(19'h7FF6F, v); chk("R5 am readback", 16'(v), 16'h24);

    dataCheck("R6 disabled", 32'h5600_0000, 6'h09, 2'b01, 0, 1);

    cfgWr(19'h7FFFB, 8'h10); mEn = 1;
    cfgRd(19'h7FFFB, v); chk("R4 enable set", 16'(v), 16'h10);

    dataCheck("R7 even byte", 32'h5600_0000, 6'h09, 2'b01, 0, 1);
    dataCheck("R7 odd byte", 32'h5600_0007, 6'h09, 2'b10, 0, 1);
    dataCheck("R8 word", 32'h5600_0012, 6'h09, 2'b00, 0, 1);
    dataCheck("R8 word top", 32'h5600_00FE, 6'h09, 2'b00, 0, 1);
    dataCheck("R6 wrong am", 32'h5600_0000, 6'h0D, 2'b01, 0, 1);
    dataCheck("R6 wrong window", 32'h5700_0000, 6'h09, 2'b01, 0, 1);
    dataCheck("R6 lword", 32'h5600_0000, 6'h09, 2'b00, 0, 0);
    dataCheck("R6 write", 32'h5600_0000, 6'h09, 2'b01, 1, 1);
    dataCheck("R3 wrong slot", {8'h00, 5'h0C, 19'h7FFFF}, 6'h2F, 2'b10, 0, 1);

    // R11 exact acknowledge latency
    @(negedge clk);
    addrIn = {8'h00, GEO, 18'h3FFFF}; amIn = 6'h2F; writeN = 1; lwordN = 1;
    @(negedge clk);
    asN = 0; dsN = 2'b10;
    @(negedge clk);
    @(negedge clk); chk("R11 not yet", 16'(dtackN), 16'h1);
    @(negedge clk); chk("R11 ack edge 3", 16'(dtackN), 16'h0);
    // R10 hold while strobes remain low
    repeat (4) @(negedge clk);
    chk("R10 hold as low", 16'(dtackOe), 16'h1);
    asN = 1;
    repeat (4) @(negedge clk);
    chk("R10 hold ds low", 16'(dtackOe), 16'h1);
    dsN = 2'b11;
    repeat (4) @(negedge clk);
    chk("R10 dropped", 16'(dtackOe), 16'h0);

    cfgWr(19'h7FFF7, 8'h10); mEn = 0;
    cfgRd(19'h7FFFB, v); chk("R4 enable clear", 16'(v), 16'h0);
    dataCheck("R4 R6 cleared", 32'h5600_0010, 6'h09, 2'b01, 0, 1);
    cfgWr(19'h7FFFB, 8'h10); mEn = 1;

    for (int k = 0; k < 150; k++) begin
      logic [31:0] a; logic [5:0] am; logic [1:0] ds; bit wr, lw;
      logic [31:0] r = $urandom;
      a = $urandom;
      if (r[0]) a[31:24] = 8'h56;
      if (r[1]) a[23:19] = GEO;
      case (r[3:2]) 2'd0: am = 6'h0D; 2'd1: am = 6'h2F; default: am = 6'h09; endcase
      case (r[5:4]) 2'd0: ds = 2'b01; 2'd1: ds = 2'b10; default: ds = 2'b00; endcase
      lw = (r[8:6] != 3'd0);
      wr = (am == 6'h09) && (r[10:9] == 2'd0);
      dataCheck(am == 6'h2F ? "R3 random" : "R6 R7 R8 random", a, am, ds, wr, lw);
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule